// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block owns the micro-program counter of a small microcoded core for a 16-bit x86-style instruction set. Every cycle it looks at the control fields of the microinstruction now being read from the control store (a next-address source code, a target address, a yield bit and an end-of-instruction bit). From those fields and from the current opcode byte, ModR/M byte, decode-done flag and pending-event lines it forms the next micro-address. The control store itself sits outside the block and is addressed by the registered micro-address output.

The address space is split in two. The lower 256 slots are indexed directly by the opcode byte, so an opcode jump lands on the first microinstruction of that opcode. Fixed entry slots lie above that range: fetch at 0x100, divide error at 0x101, reset at 0x129, non-maskable interrupt at 0x12A, maskable interrupt at 0x12B, single-step trap at 0x12C, the ModR/M wait slot at 0x12E and the bad-opcode slot at 0x12F. Group opcodes pick one of eight consecutive handlers from the ModR/M reg field, and a second branch separates the register-operand form from the memory-operand form. In the control store, prefix opcodes end the instruction at once and undefined opcodes branch to the invalid-opcode handler. The reset routine clears the datapath registers and returns to fetch.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, the micro-address is the reset entry 0x129 and the end-of-instruction strobe is low.
- R2: Source code 0 (increment) moves the micro-address to the current address plus one.
- R3: Source code 1 (jump) loads the target field.
- R4: Source code 2 (opcode) loads the opcode byte zero-extended, so opcode N continues at address N.
- R5: When the microinstruction has its yield bit set and any event is pending, the next address is that event's vector, whatever the source code. Priority runs NMI (event bit 0, 0x12A), then single-step (bit 1, 0x12C), then IRQ (bit 2, 0x12B).
- R6: Source code 3 (reg dispatch) loads the target plus ModR/M bits 5:3.
- R7: Source code 4 (operand-kind branch) loads the target when ModR/M bits 7:6 equal 2'b11 (register operand), and the target plus one otherwise.
- R8: While decode-done is low, source codes 2, 3 and 4 hold the micro-address and suppress the strobe, unless a yield to an event is taken.
- R9: Source code 5 (event) goes to the highest-priority pending vector, or to the current address plus one if nothing is pending.
- R10: The strobe is high for one cycle, the cycle after a microinstruction whose end-of-instruction bit is set advances. It is low in every other cycle.
- R11: The unassigned source codes 6 and 7 behave as increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_src | input | 3 | Next-address source code of the current microinstruction |
| ctl_target | input | ADDR_W | Target/base address field |
| ctl_yield | input | 1 | Current microinstruction yields to pending events |
| ctl_last | input | 1 | Current microinstruction ends the instruction |
| opcode_i | input | OPC_W | Opcode byte |
| modrm_i | input | 8 | ModR/M byte |
| decode_done_i | input | 1 | Opcode/ModR/M decode has completed |
| evt_pend_i | input | NUM_EVT | Pending events, bit 0 highest priority |
| uaddr_o | output | ADDR_W | Registered micro-address |
| instr_done_o | output | 1 | Registered end-of-instruction strobe |

## Verification
The bench builds the sequencer with its default parameters: a 9-bit micro-address, 8-bit opcodes and three events with vectors 0x12A, 0x12C and 0x12B. With these values the whole opcode page and every fixed slot above it can be reached by a control-store image that the bench computes, so reset, fetch, prefix and invalid opcodes, all eight reg-dispatch handlers in both operand forms, the decode stall and every combination of pending events run through the real address map. Nested priority cases with two or three events pending at once are driven directly at the fetch slot.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int SRC_W = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_INC     = 3'd0,
    SRC_JUMP    = 3'd1,
    SRC_OPCODE  = 3'd2,
    SRC_REGDISP = 3'd3,
    SRC_RMSEL   = 3'd4,
    SRC_EVENT   = 3'd5
  } useq_src_e;

  localparam logic [1:0] MOD_REGISTER = 2'b11;

endpackage

// File: rtl/useq_evt_pick.sv
module useq_evt_pick #(
  parameter int ADDR_W  = 9,
  parameter int NUM_EVT = 3,
  parameter logic [NUM_EVT*ADDR_W-1:0] EVT_VEC = {9'h12B, 9'h12C, 9'h12A}
) (
  input  logic [NUM_EVT-1:0] pend_i,
  output logic [NUM_EVT-1:0] grant_o,
  output logic               any_o,
  output logic [ADDR_W-1:0]  vec_o
);

  // Fixed priority: lower index wins.
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign grant_o[i] = pend_i[i];
    end else begin : g_rest
      assign grant_o[i] = pend_i[i] & ~(|pend_i[i-1:0]);
    end
  end

  assign any_o = |pend_i;

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (grant_o[i]) vec_o = vec_o | EVT_VEC[i*ADDR_W +: ADDR_W];
    end
  end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int OPC_W  = 8
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              yield_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [7:0]        modrm_i,
  input  logic              decode_done_i,
  input  logic              evt_any_i,
  input  logic [ADDR_W-1:0] evt_vec_i,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              advance_o
);

  useq_src_e src;
  logic      needs_decode;
  logic      take_evt;
  logic [ADDR_W-1:0] reg_field;

  assign src          = useq_src_e'(src_i);
  assign needs_decode = (src == SRC_OPCODE) || (src == SRC_REGDISP) || (src == SRC_RMSEL);
  assign take_evt     = yield_i && evt_any_i;
  assign reg_field    = ADDR_W'(modrm_i[5:3]);

  always_comb begin
    nxt_o     = cur_i + 1'b1;
    advance_o = 1'b1;
    if (take_evt) begin
      nxt_o = evt_vec_i;
    end else if (needs_decode && !decode_done_i) begin
      nxt_o     = cur_i;
      advance_o = 1'b0;
    end else begin
      case (src)
        SRC_JUMP:    nxt_o = target_i;
        SRC_OPCODE:  nxt_o = ADDR_W'(opcode_i);
        SRC_REGDISP: nxt_o = target_i + reg_field;
        SRC_RMSEL:   nxt_o = (modrm_i[7:6] == MOD_REGISTER) ? target_i : target_i + 1'b1;
        SRC_EVENT:   if (evt_any_i) nxt_o = evt_vec_i;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int OPC_W   = 8,
  parameter int NUM_EVT = 3,
  parameter logic [ADDR_W-1:0] RESET_VEC = 9'h129,
  parameter logic [NUM_EVT*ADDR_W-1:0] EVT_VEC = {9'h12B, 9'h12C, 9'h12A}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         ctl_src,
  input  logic [ADDR_W-1:0]  ctl_target,
  input  logic               ctl_yield,
  input  logic               ctl_last,
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [7:0]         modrm_i,
  input  logic               decode_done_i,
  input  logic [NUM_EVT-1:0] evt_pend_i,
  output logic [ADDR_W-1:0]  uaddr_o,
  output logic               instr_done_o
);

  logic [NUM_EVT-1:0] grant;
  logic               evt_any;
  logic [ADDR_W-1:0]  evt_vec;
  logic [ADDR_W-1:0]  nxt;
  logic               advance;
  logic [ADDR_W-1:0]  upc_q;
  logic               done_q;

  useq_evt_pick #(
    .ADDR_W (ADDR_W),
    .NUM_EVT(NUM_EVT),
    .EVT_VEC(EVT_VEC)
  ) u_pick (
    .pend_i (evt_pend_i),
    .grant_o(grant),
    .any_o  (evt_any),
    .vec_o  (evt_vec)
  );

  useq_next_addr #(
    .ADDR_W(ADDR_W),
    .OPC_W (OPC_W)
  ) u_next (
    .cur_i        (upc_q),
    .src_i        (ctl_src),
    .target_i     (ctl_target),
    .yield_i      (ctl_yield),
    .opcode_i     (opcode_i),
    .modrm_i      (modrm_i),
    .decode_done_i(decode_done_i),
    .evt_any_i    (evt_any),
    .evt_vec_i    (evt_vec),
    .nxt_o        (nxt),
    .advance_o    (advance)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upc_q  <= RESET_VEC;
      done_q <= 1'b0;
    end else begin
      upc_q  <= nxt;
      done_q <= ctl_last && advance;
    end
  end

  assign uaddr_o      = upc_q;
  assign instr_done_o = done_q;

  // ---------------------------------------------------------------------
  // Checks
  logic dep_src;
  logic yield_hit;
  assign dep_src   = (ctl_src == SRC_OPCODE) || (ctl_src == SRC_REGDISP) || (ctl_src == SRC_RMSEL);
  assign yield_hit = ctl_yield && (|evt_pend_i);

  AST_RESET_ENTRY: assert property (@(posedge clk)
    $past(rst) |-> (uaddr_o == RESET_VEC) && !instr_done_o); // R1

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant != '0) == (evt_pend_i != '0))); // R5

  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ctl_yield && evt_pend_i[0]) |=> uaddr_o == EVT_VEC[ADDR_W-1:0]); // R5

  AST_OPCODE_PAGE: assert property (@(posedge clk) disable iff (rst)
    (ctl_src == SRC_OPCODE && decode_done_i && !yield_hit) |=> (uaddr_o >> OPC_W) == '0); // R4

  AST_DISPATCH_SPAN: assert property (@(posedge clk) disable iff (rst)
    (ctl_src == SRC_REGDISP && decode_done_i && !yield_hit)
      |=> (uaddr_o - $past(ctl_target)) < ADDR_W'(8)); // R6

  AST_MEM_FORM: assert property (@(posedge clk) disable iff (rst)
    (ctl_src == SRC_RMSEL && decode_done_i && !yield_hit && modrm_i[7:6] != MOD_REGISTER)
      |=> uaddr_o == $past(ctl_target) + 1'b1); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dep_src && !decode_done_i && !yield_hit) |=> $stable(uaddr_o) && !instr_done_o); // R8

  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    instr_done_o |-> $past(ctl_last)); // R10

endmodule

// File: tb/tb_useq_sequencer.sv
module tb_useq_sequencer;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic [7:0] opc = 8'h00;
  logic [7:0] mrm = 8'h00;
  logic       dd  = 1'b1;
  logic [2:0] evt = 3'b000;

  // control store image: {yield, last, src[2:0], target[8:0]}
  logic [13:0] rom [0:511];
  logic [8:0]  uaddr;
  logic        strb;
  logic [13:0] ent;
  assign ent = rom[uaddr];

  useq_sequencer dut (
    .clk          (clk),
    .rst          (rst),
    .ctl_src      (ent[11:9]),
    .ctl_target   (ent[8:0]),
    .ctl_yield    (ent[13]),
    .ctl_last     (ent[12]),
    .opcode_i     (opc),
    .modrm_i      (mrm),
    .decode_done_i(dd),
    .evt_pend_i   (evt),
    .uaddr_o      (uaddr),
    .instr_done_o (strb)
  );

  int    total = 0;
  int    bad   = 0;
  int    m_addr = 'h129;
  bit    m_str  = 1'b0;
  string m_tag  = "R1";

  function automatic void put(int a, int src, int tgt, bit last, bit yld);
    rom[a] = {yld, last, 3'(src), 9'(tgt)};
  endfunction

  function automatic void fill_rom();
    for (int a = 0; a < 512; a++) put(a, 0, 0, 1'b0, 1'b0);
    for (int a = 0; a < 256; a++) put(a, 1, 'h100, 1'b1, 1'b0);
    put('h0F, 1, 'h130, 1'b0, 1'b0);
    for (int a = 'h63; a <= 'h67; a++) put(a, 1, 'h130, 1'b0, 1'b0);
    put('hF1, 1, 'h130, 1'b0, 1'b0);
    put('h80, 3, 'h140, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) put('h140 + k, 4, 'h150 + 2*k, 1'b0, 1'b0);
    for (int a = 'h150; a < 'h160; a++) put(a, 1, 'h100, 1'b1, 1'b0);
    put('h90, 5, 0, 1'b0, 1'b0);
    put('hD0, 1, 'h12E, 1'b0, 1'b0);
    put('hF4, 6, 'h1F0, 1'b0, 1'b0);
    put('hF5, 7, 'h1F0, 1'b0, 1'b0);
    put('h100, 2, 0, 1'b0, 1'b1);
    put('h101, 1, 'h100, 1'b1, 1'b0);
    put('h129, 1, 'h160, 1'b0, 1'b0);
    put('h16C, 1, 'h100, 1'b1, 1'b0);
    put('h12A, 1, 'h100, 1'b1, 1'b0);
    put('h12B, 1, 'h100, 1'b1, 1'b0);
    put('h12C, 1, 'h100, 1'b1, 1'b0);
    put('h12E, 2, 0, 1'b0, 1'b0);
    put('h12F, 1, 'h130, 1'b0, 1'b0);
    put('h131, 1, 'h100, 1'b1, 1'b0);
  endfunction

  // behavioural reference: next address from the requirements
  function automatic void predict();
    logic [13:0] e;
    int src, tgt, vec, nx;
    bit yld, last, adv;
    string tg;
    e    = rom[m_addr];
    src  = int'(e[11:9]);
    tgt  = int'(e[8:0]);
    yld  = e[13];
    last = e[12];
    vec  = -1;
    if (evt[0])      vec = 'h12A;
    else if (evt[1]) vec = 'h12C;
    else if (evt[2]) vec = 'h12B;
    adv = 1'b1;
    nx  = (m_addr + 1) % 512;
    tg  = "R2";
    if (yld && vec >= 0) begin
      nx = vec; tg = "R5";
    end else if ((src == 2 || src == 3 || src == 4) && !dd) begin
      nx = m_addr; adv = 1'b0; tg = "R8";
    end else begin
      case (src)
        1: begin nx = tgt; tg = "R3"; end
        2: begin nx = int'(opc); tg = "R4"; end
        3: begin nx = (tgt + int'(mrm[5:3])) % 512; tg = "R6"; end
        4: begin nx = (mrm[7:6] == 2'b11) ? tgt : (tgt + 1) % 512; tg = "R7"; end
        5: begin if (vec >= 0) nx = vec; tg = "R9"; end
        6, 7: tg = "R11";
        default: tg = "R2";
      endcase
    end
    m_addr = nx;
    m_str  = last && adv;
    m_tag  = tg;
  endfunction

  task automatic check();
    total++;
    if (uaddr !== 9'(m_addr)) begin
      bad++;
      $display("FAIL %s uaddr got %h exp %h", m_tag, uaddr, 9'(m_addr));
    end
    total++;
    if (strb !== m_str) begin
      bad++;
      $display("FAIL R10 (after %s) strobe got %b exp %b", m_tag, strb, m_str);
    end
  endtask

  task automatic cyc(input logic r, input logic [7:0] o, input logic [7:0] m,
                     input logic d, input logic [2:0] ev);
    @(negedge clk);
    check();
    rst = r; opc = o; mrm = m; dd = d; evt = ev;
    if (r) begin
      m_addr = 'h129; m_str = 1'b0; m_tag = "R1";
    end else begin
      predict();
    end
  endtask

  task automatic run(input int n, input logic [7:0] o, input logic [7:0] m,
                     input logic d, input logic [2:0] ev);
    for (int i = 0; i < n; i++) cyc(1'b0, o, m, d, ev);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    fill_rom();
    cyc(1'b1, 8'h00, 8'h00, 1'b1, 3'b000);
    // R1: reset entry, strobe low, with events and stall inputs present
    cyc(1'b1, 8'h26, 8'h00, 1'b0, 3'b111);
    run(20, 8'h00, 8'h00, 1'b1, 3'b000);          // R2 R3 R4 R10: reset code, fetch
    run(6,  8'h26, 8'h00, 1'b1, 3'b000);          // prefix: one-step instruction
    run(4,  8'hF3, 8'h00, 1'b1, 3'b000);
    run(8,  8'h0F, 8'h00, 1'b1, 3'b000);          // invalid opcode path
    run(8,  8'h65, 8'h00, 1'b1, 3'b000);
    for (int r = 0; r < 8; r++) begin
      run(5, 8'h80, {2'b11, 3'(r), 3'b001}, 1'b1, 3'b000); // R6 R7 register form
      run(5, 8'h80, {2'b01, 3'(r), 3'b110}, 1'b1, 3'b000); // R7 memory form
    end
    run(3, 8'h80, 8'hD8, 1'b0, 3'b000);           // R8 stall at fetch
    run(2, 8'h80, 8'hD8, 1'b1, 3'b000);
    run(3, 8'h80, 8'hD8, 1'b0, 3'b000);           // R8 stall at dispatch
    run(6, 8'h80, 8'hD8, 1'b1, 3'b000);
    run(4, 8'hD0, 8'h00, 1'b1, 3'b000);           // wait slot loop
    run(2, 8'hD0, 8'h00, 1'b0, 3'b000);
    run(3, 8'h00, 8'h00, 1'b1, 3'b000);
    run(4, 8'h00, 8'h00, 1'b0, 3'b111);           // R5 yield beats stall
    run(4, 8'h00, 8'h00, 1'b1, 3'b110);           // R5 step over IRQ
    run(4, 8'h00, 8'h00, 1'b1, 3'b100);           // R5 IRQ alone
    run(4, 8'h00, 8'h00, 1'b1, 3'b011);
    run(4, 8'h90, 8'h00, 1'b1, 3'b000);           // R9 nothing pending
    for (int i = 0; i < 16; i++)                   // R9 event raised only at the event slot
      cyc(1'b0, 8'h90, 8'h00, 1'b1, (m_addr == 'h90) ? 3'b110 : 3'b000);
    run(8, 8'hF4, 8'h00, 1'b1, 3'b000);           // R11 codes 6 and 7
    cyc(1'b1, 8'h00, 8'h00, 1'b1, 3'b000);        // R1 mid-run reset
    run(18, 8'h00, 8'h00, 1'b1, 3'b000);
    @(negedge clk);
    check();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog (R10 sequence hung) got timeout exp completion");
    finish_run();
  end

endmodule